// File: doc/BRIEF.md
# Ethernet PCS Link Bring-Up Sequencer

This block is the control state machine that brings a 100G-class Ethernet PCS core from power-on reset to a link that can carry traffic. It holds the core, its transmit path and its receive path in reset. It then walks a fixed chain of handshakes with the transceiver and the PCS. Each reset is released only after the status indications that guard it have been seen in turn.

On the transmit side it waits for stable lanes, DLL lock and both transfer-ready indications. It then drops the core reset, the transmit reset and finally the receive reset. Each release waits for the matching acknowledge, and the receive release also waits for the core-ready indication. On the receive side it waits for block lock, then alignment-marker lock, then deskew lock, and only then raises the link-up flag.

Every wait is bounded by a run-time timeout. When a timeout expires, the block raises an error flag and starts again from full reset. All status inputs pass through a parameterised synchronizer before use.

Top module: `pcs_linkup_seq`

## Requirements
- R1: While rst_n is low, core_rst, tx_rst and rx_rst are 1 and link_up and err are 0.
- R2: core_rst stays 1 until lanes_stable, dll_locked, tx_xfer_rdy and rx_xfer_rdy have each been seen high in that order; transfer-ready indications that arrive before lanes_stable do not release anything.
- R3: After core_rst falls, tx_rst stays 1 for as long as core_rst_ack is high, and tx_rst falls only after core_rst_ack has been seen low.
- R4: After tx_rst falls, rx_rst stays 1 until tx_rst_ack has been seen low and then core_ready has been seen high.
- R5: After rx_rst falls and rx_rst_ack has been seen low, link_up rises only after blk_lock, am_lock and deskew_lock have been seen high in that order; am_lock and deskew_lock without blk_lock leave link_up at 0.
- R6: If a wait is not satisfied within timeout_lim+1 cycles of entering it, err goes to 1, and core_rst, tx_rst and rx_rst all return to 1 in the same cycle. The sequence then restarts from the lanes_stable wait.
- R7: err, once set, stays 1 through any further timeouts. It clears in the same cycle that link_up next rises.
- R8: While link_up is 1, loss of any of blk_lock, am_lock or deskew_lock clears link_up one cycle after the synchronized loss, keeps all resets released, and resumes from the block-lock wait. The same ordered lock sequence raises link_up again.
- R9: Every output is a flop output. tx_rst is never 0 while core_rst is 1, rx_rst is never 0 while tx_rst is 1, and link_up is never 1 while rx_rst is 1.
- R10: Status inputs pass through SYNC_STAGES flop stages before the state machine sees them. With the default of 2, link_up rises on the fifth rising edge after blk_lock goes high, when am_lock and deskew_lock are already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timeout_lim | input | TW | Wait limit in cycles, sampled continuously |
| lanes_stable | input | 1 | Transceiver TX lanes stable |
| dll_locked | input | 1 | TX DLL locked |
| tx_xfer_rdy | input | 1 | TX transfer path ready |
| rx_xfer_rdy | input | 1 | RX transfer path ready |
| core_rst_ack | input | 1 | Core reset acknowledge, high while in reset |
| tx_rst_ack | input | 1 | TX reset acknowledge, high while in reset |
| core_ready | input | 1 | Core ready after TX reset release |
| rx_rst_ack | input | 1 | RX reset acknowledge, high while in reset |
| blk_lock | input | 1 | RX block lock |
| am_lock | input | 1 | RX alignment-marker lock |
| deskew_lock | input | 1 | RX deskew and lane alignment lock |
| core_rst | output | 1 | Core reset, active high |
| tx_rst | output | 1 | TX path reset, active high |
| rx_rst | output | 1 | RX path reset, active high |
| link_up | output | 1 | Link ready for traffic |
| err | output | 1 | Sticky timeout flag |

## Verification
The assertions check the reset nesting, the rule that link_up implies released resets, and the gating of each reset edge by the synchronized status it depends on. They also check that a timeout reasserts all resets and that a lock loss drops link_up on the next cycle. These hold on every cycle. Only the bench scenarios can show the ordered waits as sequences: early indications that must be ignored, the exact bit-to-link latency, and recovery from a timeout back to a clean link. A scoreboard checks the full order of output changes across these scenarios.

// File: rtl/lk_seq_pkg.sv
package lk_seq_pkg;

   localparam int NSTAT    = 11;
   localparam int IX_LANES = 0;
   localparam int IX_DLL   = 1;
   localparam int IX_TXXR  = 2;
   localparam int IX_RXXR  = 3;
   localparam int IX_CACK  = 4;
   localparam int IX_TACK  = 5;
   localparam int IX_CRDY  = 6;
   localparam int IX_RACK  = 7;
   localparam int IX_BLK   = 8;
   localparam int IX_AM    = 9;
   localparam int IX_DSK   = 10;

   // Order matters: reset outputs are decoded by comparison against it.
   typedef enum logic [3:0] {
      S_RST,
      S_LANES,
      S_DLL,
      S_TXXR,
      S_RXXR,
      S_CACK,
      S_TACK,
      S_CRDY,
      S_RACK,
      S_BLK,
      S_AM,
      S_DSK,
      S_UP
   } seq_state_e;

endpackage

// File: rtl/lk_sync_bus.sv
module lk_sync_bus #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end

         assign q = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/lk_wait_timer.sv
module lk_wait_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic [TW-1:0] lim,
   output logic          expired
);

   logic [TW-1:0] cnt_q;

   // Saturating count of cycles spent in the current state.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (clear)           cnt_q <= '0;
      else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q >= lim);

endmodule

// File: rtl/lk_seq_fsm.sv
module lk_seq_fsm
   import lk_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSTAT-1:0] st,
   input  logic             expired,
   output logic             timer_clr,
   output logic             core_rst,
   output logic             tx_rst,
   output logic             rx_rst,
   output logic             link_up,
   output logic             err
);

   seq_state_e state_q, nxt, fwd;
   logic       waiting, go, fall, tmo;
   logic       all_locks;

   assign all_locks = st[IX_BLK] & st[IX_AM] & st[IX_DSK];

   always_comb begin
      nxt     = state_q;
      fwd     = state_q;
      waiting = 1'b1;
      go      = 1'b0;
      fall    = 1'b0;
      tmo     = 1'b0;
      case (state_q)
         S_RST:   begin waiting = 1'b0; nxt = S_LANES;                 end
         S_LANES: begin go = st[IX_LANES];  fwd = S_DLL;               end
         S_DLL:   begin go = st[IX_DLL];    fwd = S_TXXR;              end
         S_TXXR:  begin go = st[IX_TXXR];   fwd = S_RXXR;              end
         S_RXXR:  begin go = st[IX_RXXR];   fwd = S_CACK;              end
         S_CACK:  begin go = !st[IX_CACK];  fwd = S_TACK;              end
         S_TACK:  begin go = !st[IX_TACK];  fwd = S_CRDY;              end
         S_CRDY:  begin go = st[IX_CRDY];   fwd = S_RACK;              end
         S_RACK:  begin go = !st[IX_RACK];  fwd = S_BLK;               end
         S_BLK:   begin go = st[IX_BLK];    fwd = S_AM;                end
         S_AM:    begin go = st[IX_AM];     fwd = S_DSK;
                        fall = !st[IX_BLK];                            end
         S_DSK:   begin go = st[IX_DSK];    fwd = S_UP;
                        fall = !(st[IX_BLK] & st[IX_AM]);              end
         S_UP:    begin waiting = 1'b0; fall = !all_locks;             end
         default: begin waiting = 1'b0; nxt = S_RST;                   end
      endcase
      if (fall)                     nxt = S_BLK;
      else if (waiting && go)       nxt = fwd;
      else if (waiting && expired)  begin nxt = S_RST; tmo = 1'b1;    end
   end

   assign timer_clr = (nxt != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_RST;
         core_rst <= 1'b1;
         tx_rst   <= 1'b1;
         rx_rst   <= 1'b1;
         link_up  <= 1'b0;
         err      <= 1'b0;
      end else begin
         state_q  <= nxt;
         core_rst <= (nxt <= S_RXXR);
         tx_rst   <= (nxt <= S_CACK);
         rx_rst   <= (nxt <= S_CRDY);
         link_up  <= (nxt == S_UP);
         if (tmo)               err <= 1'b1;
         else if (nxt == S_UP)  err <= 1'b0;
      end
   end

endmodule

// File: rtl/pcs_linkup_seq.sv
module pcs_linkup_seq
   import lk_seq_pkg::*;
#(
   parameter int TW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] timeout_lim,
   input  logic          lanes_stable,
   input  logic          dll_locked,
   input  logic          tx_xfer_rdy,
   input  logic          rx_xfer_rdy,
   input  logic          core_rst_ack,
   input  logic          tx_rst_ack,
   input  logic          core_ready,
   input  logic          rx_rst_ack,
   input  logic          blk_lock,
   input  logic          am_lock,
   input  logic          deskew_lock,
   output logic          core_rst,
   output logic          tx_rst,
   output logic          rx_rst,
   output logic          link_up,
   output logic          err
);

   if (TW < 2) begin : g_bad_tw
      $error("pcs_linkup_seq: TW must be at least 2");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("pcs_linkup_seq: SYNC_STAGES must be 0 to 4");
   end

   logic [NSTAT-1:0] st_raw, st_s;
   logic             timer_clr, expired;

   assign st_raw = {deskew_lock, am_lock, blk_lock, rx_rst_ack, core_ready,
                    tx_rst_ack, core_rst_ack, rx_xfer_rdy, tx_xfer_rdy,
                    dll_locked, lanes_stable};

   lk_sync_bus #(.W(NSTAT), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (st_raw),
      .q     (st_s)
   );

   lk_wait_timer #(.TW(TW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (timer_clr),
      .lim     (timeout_lim),
      .expired (expired)
   );

   lk_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .st        (st_s),
      .expired   (expired),
      .timer_clr (timer_clr),
      .core_rst  (core_rst),
      .tx_rst    (tx_rst),
      .rx_rst    (rx_rst),
      .link_up   (link_up),
      .err       (err)
   );

endmodule

// File: rtl/lk_seq_chk.sv
module lk_seq_chk
   import lk_seq_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic [NSTAT-1:0] st_s,
   input logic             core_rst,
   input logic             tx_rst,
   input logic             rx_rst,
   input logic             link_up,
   input logic             err
);

   // R9: reset nesting
   p_tx_nest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_rst |-> !core_rst);
   p_rx_nest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_rst |-> !tx_rst);
   p_up_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
      link_up |-> !rx_rst);

   // R2: core release follows RX transfer ready
   p_core_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst) |-> $past(st_s[IX_RXXR]));

   // R3: TX release follows core acknowledge low
   p_tx_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_rst) |-> !$past(st_s[IX_CACK]));

   // R4: RX release follows core ready
   p_rx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_rst) |-> $past(st_s[IX_CRDY]));

   // R5: link up follows deskew lock
   p_up_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_up) |-> $past(st_s[IX_DSK]));

   // R6: timeout reasserts every reset
   p_err_resets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (core_rst && tx_rst && rx_rst));

   // R7: err clears only with link up
   p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err) |-> link_up);

   // R8: lock loss drops link up next cycle
   p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up && !(st_s[IX_BLK] && st_s[IX_AM] && st_s[IX_DSK])) |=> !link_up);

endmodule

bind pcs_linkup_seq lk_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .st_s     (st_s),
   .core_rst (core_rst),
   .tx_rst   (tx_rst),
   .rx_rst   (rx_rst),
   .link_up  (link_up),
   .err      (err)
);

// File: tb/sim_pcs_linkup_seq.sv
module sim_pcs_linkup_seq;

   localparam int TW = 16;
   localparam int SS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [TW-1:0] timeout_lim = 16'd200;
   logic lanes_stable = 0, dll_locked = 0, tx_xfer_rdy = 0, rx_xfer_rdy = 0;
   logic core_rst_ack = 1, tx_rst_ack = 1, core_ready = 0, rx_rst_ack = 1;
   logic blk_lock = 0, am_lock = 0, deskew_lock = 0;
   logic core_rst, tx_rst, rx_rst, link_up, err;

   int nchk = 0;
   int nerr = 0;
   logic [4:0] expv [$];
   string      expt [$];
   logic       mon_en = 1'b0;
   logic [4:0] prev;

   always #2 clk = ~clk;

   pcs_linkup_seq #(.TW(TW), .SYNC_STAGES(SS)) u0 (
      .clk(clk), .rst_n(rst_n), .timeout_lim(timeout_lim),
      .lanes_stable(lanes_stable), .dll_locked(dll_locked),
      .tx_xfer_rdy(tx_xfer_rdy), .rx_xfer_rdy(rx_xfer_rdy),
      .core_rst_ack(core_rst_ack), .tx_rst_ack(tx_rst_ack),
      .core_ready(core_ready), .rx_rst_ack(rx_rst_ack),
      .blk_lock(blk_lock), .am_lock(am_lock), .deskew_lock(deskew_lock),
      .core_rst(core_rst), .tx_rst(tx_rst), .rx_rst(rx_rst),
      .link_up(link_up), .err(err)
   );

   function automatic logic [4:0] outs();
      return {core_rst, tx_rst, rx_rst, link_up, err};
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [4:0] act, input logic [4:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %b expected %b (core,tx,rx,up,err)", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_chg(input logic [4:0] v, input string tag);
      expv.push_back(v);
      expt.push_back(tag);
   endtask

   // Monitor: every output change is popped against the scoreboard.
   always @(negedge clk) begin
      if (mon_en && outs() !== prev) begin
         if (expv.size() == 0) begin
            chk(1'b0, "R9 unexpected change", outs(), prev);
         end else begin
            logic [4:0] e;
            string t;
            e = expv.pop_front();
            t = expt.pop_front();
            chk(outs() === e, t, outs(), e);
         end
         prev = outs();
      end
   end

   task automatic bring_up(input logic e);
      expect_chg({5'b01100} | {4'b0, e}, "R2 core release");
      lanes_stable = 1; step(6);
      dll_locked = 1;   step(6);
      tx_xfer_rdy = 1;  step(6);
      rx_xfer_rdy = 1;  step(20);
      chk(tx_rst === 1'b1, "R3 tx held by core ack", outs(), {5'b01100} | {4'b0, e});
      expect_chg({5'b00100} | {4'b0, e}, "R3 tx release");
      core_rst_ack = 0; step(20);
      chk(rx_rst === 1'b1, "R4 rx held by tx ack", outs(), {5'b00100} | {4'b0, e});
      tx_rst_ack = 0;   step(20);
      chk(rx_rst === 1'b1, "R4 rx held by core ready", outs(), {5'b00100} | {4'b0, e});
      expect_chg({5'b00000} | {4'b0, e}, "R4 rx release");
      core_ready = 1;   step(8);
      rx_rst_ack = 0;   step(8);
      am_lock = 1; deskew_lock = 1; step(20);
      chk(link_up === 1'b0, "R5 no link without block lock", outs(), {5'b00000} | {4'b0, e});
      expect_chg(5'b00010, "R5 R7 link up");
      blk_lock = 1;
      repeat (SS + 2) @(posedge clk);
      @(negedge clk);
      chk(link_up === 1'b0, "R10 link not yet up", outs(), {5'b00000} | {4'b0, e});
      @(posedge clk);
      @(negedge clk);
      chk(link_up === 1'b1, "R10 link up latency", outs(), 5'b00010);
      step(10);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin : driver
      step(5);
      chk(outs() === 5'b11100, "R1 reset state", outs(), 5'b11100);
      rst_n = 1'b1;
      prev = 5'b11100;
      mon_en = 1'b1;

      // Transfer-ready before lanes stable must not release anything.
      rx_xfer_rdy = 1; tx_xfer_rdy = 1; dll_locked = 1;
      timeout_lim = 16'd1000;
      step(30);
      chk(outs() === 5'b11100, "R2 early indications ignored", outs(), 5'b11100);
      dll_locked = 0; tx_xfer_rdy = 0; rx_xfer_rdy = 0;
      timeout_lim = 16'd200;
      step(4);
      bring_up(1'b0);

      // Lock loss after link up, then relock.
      expect_chg(5'b00000, "R8 link drop");
      am_lock = 0; step(8);
      chk(outs() === 5'b00000, "R8 resets stay released", outs(), 5'b00000);
      expect_chg(5'b00010, "R8 relock");
      am_lock = 1; step(12);

      // Timeout in the block-lock wait.
      timeout_lim = 16'd10;
      expect_chg(5'b00000, "R8 drop before timeout");
      expect_chg(5'b11101, "R6 timeout full reset");
      blk_lock = 0; lanes_stable = 0; step(40);
      chk(outs() === 5'b11101, "R6 err with all resets", outs(), 5'b11101);
      core_rst_ack = 1; tx_rst_ack = 1; rx_rst_ack = 1; core_ready = 0;
      am_lock = 0; deskew_lock = 0;
      dll_locked = 0; tx_xfer_rdy = 0; rx_xfer_rdy = 0;
      step(60);
      chk(err === 1'b1, "R7 err sticky over repeated timeouts", outs(), 5'b11101);
      timeout_lim = 16'd200;
      step(2);
      bring_up(1'b1);
      chk(err === 1'b0, "R7 err cleared at link up", outs(), 5'b00010);

      step(5);
      chk(expv.size() == 0, "R9 all expected changes seen",
          5'(expv.size()), 5'd0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule